// File: doc/BRIEF.md
# Shared Disk Bus Ownership Controller

This block sits between a USB-to-disk bridge and a parallel ATA/ATAPI disk bus that the bridge shares with an external media-player processor. It decides, cycle by cycle, whether the bridge may drive that bus. If the bridge may not drive the bus, the block floats every IDE output: data, strobes, address and chip selects. It also reports on a status line whether the bridge currently owns the bus. A separate drive-reset line is passed through for firmware.

Ownership depends on three inputs:

- A permission input, which also carries VBUS and which the external processor can hold low to force a detach.
- The suspend indication from the USB side.
- A link-state code from the USB side.

The bridge drives the disk bus only when all of these hold: permission is high, the link is configured, and the link is not suspended. The permission input and the suspend input are asynchronous. Each passes through a two-stage synchronizer.

When ownership is withdrawn while the protocol engine is in the middle of a cycle, the block first forces the engine's strobes inactive. Only after that does it float the bus. The drive therefore never sees a strobe cut off by a floating line.

During enumeration the status line is shared with a serial-EEPROM line. In that state the status line carries the EEPROM signal instead of an ownership flag.

Top module: `ide_share_ctrl`

## Requirements
- R1: While the synchronized permission input is low, the block settles with `ide_oe`=0 and `host_status`=0, for every link code and suspend level.
- R2: With permission high, any of the following settles the block with `ide_oe`=0 and `host_status`=0: link code 4 (suspended), link code 5 (safely removed), or `susp_in`=1.
- R3: With permission high and `susp_in`=0, link codes 0 (unpowered), 1 (unconnected), 6 and 7 (undefined, treated as unconnected) settle the block with `ide_oe`=0 and `host_status`=0.
- R4: With permission high, `susp_in`=0 and link code 3 (configured), the block settles with `ide_oe`=1, `host_status`=1, and `ide_strb_n` equal to `eng_strb_n`.
- R5: With permission high, `susp_in`=0 and link code 2 (enumerating), `ide_oe`=0 and `host_status` follows `ee_line`.
- R6: The permission input and the suspend input pass through two flip-flops. A change applied between edges has no effect on `ide_oe` after the second rising edge and takes effect after the third.
- R7: On leaving the owning state, `ide_strb_n` is forced to all ones from the first cycle in which the exit condition is visible. `ide_oe` stays 1 for exactly one further edge and then drops. When the exit is caused by the synchronized permission input, `ide_oe` falls after the fourth edge following the input change. When it is caused by the link code, `ide_oe` falls after the second edge.
- R8: `ata_reset` equals `fw_rst_req` as sampled at the previous rising edge, whatever the ownership state.
- R9: During and straight after reset, `ide_oe`=0, `host_status`=0, `ide_strb_n` is all ones and `ata_reset`=1.
- R10: Whenever `ide_oe`=0, `ide_strb_n` is all ones, whatever `eng_strb_n` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| perm_in | input | 1 | Asynchronous permission/VBUS input; low forces a detach |
| susp_in | input | 1 | Asynchronous USB suspend indication, active high |
| link_code | input | 3 | Synchronous link state: 0 unpowered, 1 unconnected, 2 enumerating, 3 configured, 4 suspended, 5 safely removed, 6–7 undefined |
| ee_line | input | 1 | Serial-EEPROM line value shown on the status output during enumeration |
| fw_rst_req | input | 1 | Firmware drive-reset request, active high |
| eng_strb_n | input | STRB_W | Active-low strobes from the ATA protocol engine |
| ide_oe | output | 1 | Output enable for all IDE outputs; 0 floats the bus |
| ide_strb_n | output | STRB_W | Gated active-low strobes toward the drive |
| host_status | output | 1 | Ownership status toward the external processor |
| ata_reset | output | 1 | Drive-reset line, active high |

## Verification
The hardest situation to reach from the ports is the withdrawal of ownership while the engine holds a strobe active. Here the bench must see three things in order: the strobes go inactive, the bus is still driven for exactly one more cycle, and only then does the bus float.

To reach it, the bench puts the block into the owning state with every engine strobe held low. It then withdraws permission, or switches the link code, at a known falling edge. After that it samples the strobes and `ide_oe` at each of the following falling edges.

A full sweep over every combination of permission, suspend, link code and EEPROM level then checks each settled state against an independently written decision table.

// File: rtl/share_pkg.sv
package share_pkg;

  typedef enum logic [1:0] {
    MODE_DETACHED = 2'd0,
    MODE_ENUM     = 2'd1,
    MODE_ACTIVE   = 2'd2,
    MODE_SUSP     = 2'd3
  } mode_t;

  localparam logic [2:0] LNK_UNPOWERED  = 3'd0;
  localparam logic [2:0] LNK_UNCONNECT  = 3'd1;
  localparam logic [2:0] LNK_ENUM       = 3'd2;
  localparam logic [2:0] LNK_CONFIGURED = 3'd3;
  localparam logic [2:0] LNK_SUSPENDED  = 3'd4;
  localparam logic [2:0] LNK_REMOVED    = 3'd5;

  // Ownership decision from synchronized inputs.
  function automatic mode_t pick_mode(input logic perm, input logic susp,
                                      input logic [2:0] link);
    mode_t m;
    if (!perm) m = MODE_DETACHED;
    else if (susp || link == LNK_SUSPENDED || link == LNK_REMOVED) m = MODE_SUSP;
    else if (link == LNK_ENUM) m = MODE_ENUM;
    else if (link == LNK_CONFIGURED) m = MODE_ACTIVE;
    else m = MODE_DETACHED;
    return m;
  endfunction

endpackage

// File: rtl/share_sync.sv
module share_sync #(
  parameter int STAGES  = 2,
  parameter int W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= {W{RST_VAL}};
          else        chain[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= {W{RST_VAL}};
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/share_fsm.sv
module share_fsm
  import share_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       perm_s,
  input  logic       susp_s,
  input  logic [2:0] link,
  output mode_t      mode_o,
  output logic       quiesce_o,
  output logic       leave_o
);
  mode_t mode_q, exit_q, target;
  logic  quiesce_q, leave;

  assign target = pick_mode(perm_s, susp_s, link);
  // First cycle in which the owning state must be given up.
  assign leave  = (mode_q == MODE_ACTIVE) && !quiesce_q && (target != MODE_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_DETACHED;
      exit_q    <= MODE_DETACHED;
      quiesce_q <= 1'b0;
    end else if (quiesce_q) begin
      mode_q    <= exit_q;
      quiesce_q <= 1'b0;
    end else if (leave) begin
      exit_q    <= target;
      quiesce_q <= 1'b1;
    end else begin
      mode_q    <= target;
    end
  end

  assign mode_o    = mode_q;
  assign quiesce_o = quiesce_q;
  assign leave_o   = leave;

  assert_detach_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!perm_s && !quiesce_q && mode_q != MODE_ACTIVE) |=> mode_q == MODE_DETACHED);
  assert_suspend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_s && susp_s && !quiesce_q && mode_q != MODE_ACTIVE) |=> mode_q == MODE_SUSP);
  assert_leave_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> (quiesce_q && mode_q == MODE_ACTIVE));
  assert_quiesce_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    quiesce_q |=> (!quiesce_q && mode_q != MODE_ACTIVE));
endmodule

// File: rtl/share_outgate.sv
module share_outgate
  import share_pkg::*;
#(
  parameter int STRB_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode,
  input  logic              quiesce,
  input  logic              leave,
  input  logic              ee_line,
  input  logic              fw_rst_req,
  input  logic [STRB_W-1:0] eng_strb_n,
  output logic              ide_oe,
  output logic [STRB_W-1:0] ide_strb_n,
  output logic              status,
  output logic              ata_reset
);
  logic hold_strb, owner_ok;

  assign ide_oe    = (mode == MODE_ACTIVE);
  assign hold_strb = !ide_oe || quiesce || leave;
  assign owner_ok  = ide_oe && !quiesce && !leave;

  always_comb begin
    ide_strb_n = hold_strb ? {STRB_W{1'b1}} : eng_strb_n;
    if (mode == MODE_ENUM) status = ee_line;
    else                   status = owner_ok;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ata_reset <= 1'b1;
    else        ata_reset <= fw_rst_req;

  assert_status_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_ENUM && status) |-> ide_oe);
  assert_strb_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_oe |-> (&ide_strb_n));
  assert_rst_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ata_reset) |-> $past(fw_rst_req));
endmodule

// File: rtl/ide_share_ctrl.sv
module ide_share_ctrl
  import share_pkg::*;
#(
  parameter int STRB_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              perm_in,
  input  logic              susp_in,
  input  logic [2:0]        link_code,
  input  logic              ee_line,
  input  logic              fw_rst_req,
  input  logic [STRB_W-1:0] eng_strb_n,
  output logic              ide_oe,
  output logic [STRB_W-1:0] ide_strb_n,
  output logic              host_status,
  output logic              ata_reset
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0] raw_in, synced;
  mode_t mode;
  logic  quiesce, leave;

  assign raw_in = {susp_in, perm_in};

  share_sync #(.STAGES(SYNC_STAGES), .W(NSYNC), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_in), .q_sync(synced));

  share_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .perm_s(synced[0]), .susp_s(synced[1]),
    .link(link_code), .mode_o(mode), .quiesce_o(quiesce), .leave_o(leave));

  share_outgate #(.STRB_W(STRB_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .mode(mode), .quiesce(quiesce), .leave(leave),
    .ee_line(ee_line), .fw_rst_req(fw_rst_req), .eng_strb_n(eng_strb_n),
    .ide_oe(ide_oe), .ide_strb_n(ide_strb_n), .status(host_status),
    .ata_reset(ata_reset));

  // Strobes must already be idle in the cycle before the bus floats.
  assert_float_after_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ide_oe) |-> (&$past(ide_strb_n)));
endmodule

// File: tb/tb_ide_share_ctrl.sv
module tb_ide_share_ctrl;
  localparam int SW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic perm_in = 1'b0, susp_in = 1'b0, ee_line = 1'b0, fw_rst_req = 1'b1;
  logic [2:0] link_code = 3'd0;
  logic [SW-1:0] eng_strb_n = '1;
  logic ide_oe, host_status, ata_reset;
  logic [SW-1:0] ide_strb_n;

  int n_cmp = 0, n_bad = 0;

  ide_share_ctrl #(.STRB_W(SW)) dut (.*);

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Independent restatement of the ownership table: 0 float, 1 own, 2 enumerate.
  function automatic int expect_kind(input logic p, input logic s, input logic [2:0] l);
    if (p === 1'b0) return 0;
    case (l)
      3'd3: return s ? 0 : 1;
      3'd2: return s ? 0 : 2;
      default: return 0;
    endcase
  endfunction

  initial begin
    wait_n(2);
    chk("R9 oe in reset", {7'd0, ide_oe}, 8'd0);
    chk("R9 status in reset", {7'd0, host_status}, 8'd0);
    chk("R9 strobes in reset", {5'd0, ide_strb_n}, 8'h07);
    chk("R9 drive reset in reset", {7'd0, ata_reset}, 8'd1);
    rst_n = 1'b1;
    wait_n(1);
    chk("R9 oe after reset", {7'd0, ide_oe}, 8'd0);
    chk("R9 drive reset after reset", {7'd0, ata_reset}, 8'd1);

    // R6: synchronizer latency on entry.
    link_code = 3'd3; eng_strb_n = 3'b010;
    wait_n(3);
    perm_in = 1'b1;
    wait_n(2);
    chk("R6 oe after two edges", {7'd0, ide_oe}, 8'd0);
    wait_n(1);
    chk("R6 oe after three edges", {7'd0, ide_oe}, 8'd1);
    chk("R4 strobes pass", {5'd0, ide_strb_n}, {5'd0, 3'b010});

    // R8: drive reset follows firmware independent of state.
    fw_rst_req = 1'b0;
    wait_n(1);
    chk("R8 drive reset cleared", {7'd0, ata_reset}, 8'd0);
    fw_rst_req = 1'b1;
    wait_n(1);
    chk("R8 drive reset set", {7'd0, ata_reset}, 8'd1);
    fw_rst_req = 1'b0;

    // R7: pre-emption on permission drop with strobes active.
    eng_strb_n = 3'b000;
    wait_n(1);
    chk("R4 active strobes", {5'd0, ide_strb_n}, 8'd0);
    perm_in = 1'b0;
    wait_n(1);
    chk("R7 edge1 strobes", {5'd0, ide_strb_n}, 8'd0);
    wait_n(1);
    chk("R7 edge2 strobes idle", {5'd0, ide_strb_n}, 8'h07);
    chk("R7 edge2 oe held", {7'd0, ide_oe}, 8'd1);
    chk("R7 edge2 status", {7'd0, host_status}, 8'd0);
    wait_n(1);
    chk("R7 edge3 oe held", {7'd0, ide_oe}, 8'd1);
    chk("R7 edge3 strobes idle", {5'd0, ide_strb_n}, 8'h07);
    wait_n(1);
    chk("R7 edge4 oe float", {7'd0, ide_oe}, 8'd0);
    chk("R10 strobes while floating", {5'd0, ide_strb_n}, 8'h07);
    chk("R1 status detached", {7'd0, host_status}, 8'd0);

    // R7: pre-emption on link change (no synchronizer).
    perm_in = 1'b1;
    wait_n(5);
    chk("R4 re-owned", {7'd0, ide_oe}, 8'd1);
    link_code = 3'd4;
    #1;
    chk("R7 link exit strobes at once", {5'd0, ide_strb_n}, 8'h07);
    wait_n(1);
    chk("R7 link edge1 oe held", {7'd0, ide_oe}, 8'd1);
    wait_n(1);
    chk("R7 link edge2 oe float", {7'd0, ide_oe}, 8'd0);
    chk("R2 status suspended", {7'd0, host_status}, 8'd0);

    // Exhaustive settled-state sweep.
    for (int i = 0; i < 64; i++) begin
      logic p, s, e;
      logic [2:0] l;
      int k;
      logic [SW-1:0] pat;
      p = i[5]; s = i[4]; l = i[3:1]; e = i[0];
      pat = SW'(i * 5 + 1);
      perm_in = p; susp_in = s; link_code = l; ee_line = e; eng_strb_n = pat;
      wait_n(6);
      k = expect_kind(p, s, l);
      if (!p)
        chk("R1 sweep oe", {7'd0, ide_oe}, 8'd0);
      else if (s || l == 3'd4 || l == 3'd5)
        chk("R2 sweep oe", {7'd0, ide_oe}, 8'd0);
      else if (k == 0)
        chk("R3 sweep oe", {7'd0, ide_oe}, 8'd0);
      else
        chk("R4 sweep oe", {7'd0, ide_oe}, {7'd0, k == 1});
      if (k == 2)
        chk("R5 sweep status mirrors eeprom", {7'd0, host_status}, {7'd0, e});
      else
        chk("R4 sweep status", {7'd0, host_status}, {7'd0, k == 1});
      chk("R10 sweep strobes", {5'd0, ide_strb_n},
          {5'd0, (k == 1) ? pat : {SW{1'b1}}});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule